// File: doc/BRIEF.md
# Uncorrectable Error Header Log Queue

This block keeps the header log that goes with uncorrectable error reporting, and it can hold more than one error at a time. Each error that arrives carries a status vector with exactly one bit set, four header dwords, four prefix dwords and two flags: header valid and prefix present. The block keeps one live log set. This set holds the first-error pointer, a prefix-logged bit, the header log and the prefix log. It also holds the uncorrectable status register that the logged errors set. While the first error is still unacknowledged and multiple-header recording is turned on, later errors wait in a bounded FIFO.

Software acknowledges errors with write-one-to-clear writes to the status register. A write that clears the bit named by the first-error pointer moves the queue forward: the oldest waiting error becomes the live one. A write that clears only other bits leaves the status bits of queued errors set, because the queue sets them again. A write to the control register turns recording on or off. Turning recording off flushes the queue. When the queue is full, an extra error is dropped and a one-cycle overflow pulse goes out. Correctable-error logic turns that pulse into a header-log-overflow error. All outputs are registered and appear on the cycle after the input that caused them.

Top module: `aer_hlog_queue`

## Requirements
- R1: An arriving error whose status vector is zero or has more than one bit set is rejected. `err_reject` pulses in the next cycle. Status, log and queue do not change.
- R2: An error that is logged directly loads `first_err_ptr` with the index of its single set bit. Every accepted error sets its own bit in `unc_status`, whether it is logged, queued or dropped.
- R3: When header valid is set, each logged header dword is the input dword with its four bytes reversed. Dword d sits at bits [32d+31:32d]. When header valid is clear, the header log is zero.
- R4: The prefix log holds the byte-reversed prefix dwords and `pfx_logged` is set only when the error's prefix-present flag and `pfx_supported` are both high. Otherwise the prefix log and `pfx_logged` are zero.
- R5: A valid error goes to the queue, and not to the log, only when recording is enabled and the `unc_status` bit at `first_err_ptr` is set. Otherwise it overwrites the live log.
- R6: A valid error that should be queued while the queue holds DEPTH entries is dropped. `hdr_log_overflow` pulses in the next cycle.
- R7: A write after which the `unc_status` bit at `first_err_ptr` is clear, made while recording is enabled and the queue is not empty, does three things. It sets the status bits of all queued errors again. It pops the oldest entry. It loads that entry as the live log.
- R8: A write after which the bit at `first_err_ptr` is clear, made while recording is disabled or the queue is empty, clears the pointer, `pfx_logged` and both logs to zero.
- R9: A write that leaves the bit at `first_err_ptr` set while recording is enabled sets the status bits of every queued error again. This undoes any clear of those bits.
- R10: A write that leaves recording disabled flushes the whole queue (`q_count` becomes 0).
- R11: `cfg_sel`=1 writes the control register, and bit 0 of `cfg_wdata` is the recording enable. The enable can only be set, and `mhr_capable` is only high, when DEPTH > 0. `cfg_sel`=0 is a write-one-to-clear on `unc_status`.
- R12: When a configuration write and an error arrive in the same cycle, the write is applied first. The error is then judged against the state left by the write.
- R13: After reset, status, pointer, logs, enable, pulses and `q_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | An error is presented this cycle |
| err_status | input | 32 | One-hot uncorrectable status of the error |
| err_hdr_valid | input | 1 | Header dwords are meaningful |
| err_pfx_present | input | 1 | Prefix dwords are meaningful |
| err_hdr | input | 128 | Four header dwords, dword 0 in the low bits |
| err_pfx | input | 128 | Four prefix dwords, dword 0 in the low bits |
| pfx_supported | input | 1 | End-to-end prefix support is advertised |
| cfg_we | input | 1 | Software configuration write strobe |
| cfg_sel | input | 1 | 0: status write-one-to-clear, 1: control write |
| cfg_wdata | input | 32 | Write data |
| unc_status | output | 32 | Uncorrectable status register |
| first_err_ptr | output | 5 | Bit index of the live first error |
| pfx_logged | output | 1 | Prefix log holds a valid prefix |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| mhr_capable | output | 1 | Multiple-header recording can be enabled |
| mhr_enable | output | 1 | Multiple-header recording enabled |
| err_reject | output | 1 | Pulse: last error had an invalid status vector |
| hdr_log_overflow | output | 1 | Pulse: last error was dropped on a full queue |
| q_count | output | $clog2(DEPTH+1) | Number of queued errors |

## Verification
Some properties are checked on every cycle. A rejected error leaves status, pointer and queue untouched. A directly logged error leaves its own status bit set under the pointer. A missing header or prefix leaves its log zero. Overflow only happens with a full queue. The queue is always empty while recording is off, and it never pushes past DEPTH or pops when empty. Other behaviour needs the bench's scenarios and its per-cycle reference model: byte reversal of logged dwords, re-setting the status bits of queued errors, the oldest-first order in which queued errors reach the log, and the ordering when a write and an error arrive in the same cycle.

// File: rtl/aer_hlog_pkg.sv
package aer_hlog_pkg;

  localparam int STAT_W = 32;
  localparam int DW_W   = 32;
  localparam int DW_N   = 4;
  localparam int LOG_W  = DW_W * DW_N;
  localparam int IDX_W  = $clog2(STAT_W);

  typedef struct packed {
    logic              pfx_present;
    logic              hdr_valid;
    logic [LOG_W-1:0]  pfx;
    logic [LOG_W-1:0]  hdr;
    logic [STAT_W-1:0] status;
  } err_rec_t;

  localparam int REC_W = $bits(err_rec_t);

endpackage

// File: rtl/aer_hlog_fmt.sv
// Turns one error record into the values the live log registers take.
module aer_hlog_fmt
  import aer_hlog_pkg::*;
(
  input  err_rec_t          rec,
  input  logic              pfx_supported,
  output logic              ok,
  output logic [IDX_W-1:0]  idx,
  output logic [LOG_W-1:0]  hdr_log,
  output logic [LOG_W-1:0]  pfx_log,
  output logic              pfx_valid
);

  localparam int BYTES = DW_W / 8;

  logic [LOG_W-1:0] hdr_sw;
  logic [LOG_W-1:0] pfx_sw;

  assign ok = $onehot(rec.status);

  always_comb begin
    idx = '0;
    for (int i = 0; i < STAT_W; i++) begin
      if (rec.status[i]) idx = IDX_W'(i);
    end
  end

  for (genvar d = 0; d < DW_N; d++) begin : g_dw
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign hdr_sw[d*DW_W + b*8 +: 8] = rec.hdr[d*DW_W + (BYTES-1-b)*8 +: 8];
      assign pfx_sw[d*DW_W + b*8 +: 8] = rec.pfx[d*DW_W + (BYTES-1-b)*8 +: 8];
    end
  end

  assign pfx_valid = rec.pfx_present & pfx_supported;
  assign hdr_log   = rec.hdr_valid ? hdr_sw : '0;
  assign pfx_log   = pfx_valid ? pfx_sw : '0;

endmodule

// File: rtl/aer_hlog_fifo.sv
// Bounded FIFO of waiting errors, with an OR of the status bits of all
// occupied slots.
module aer_hlog_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64,
  parameter int ORW   = 32,
  localparam int CW   = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   din,
  input  logic           pop,
  input  logic           flush,
  output logic [W-1:0]   head,
  output logic [CW-1:0]  count,
  output logic [ORW-1:0] or_all
);

  if (DEPTH == 0) begin : g_none
    assign head   = '0;
    assign count  = '0;
    assign or_all = '0;
  end else begin : g_fifo
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr_q, rd_ptr_d;
    logic [PW-1:0] wr_ptr_q, wr_ptr_d;
    logic [CW-1:0] cnt_q, cnt_d;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
      rd_ptr_d = rd_ptr_q;
      wr_ptr_d = wr_ptr_q;
      cnt_d    = cnt_q;
      if (flush) begin
        rd_ptr_d = '0;
        wr_ptr_d = '0;
        cnt_d    = '0;
      end else begin
        if (pop)  rd_ptr_d = nxt(rd_ptr_q);
        if (push) wr_ptr_d = nxt(wr_ptr_q);
        if (push && !pop)      cnt_d = cnt_q + 1'b1;
        else if (pop && !push) cnt_d = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
        cnt_q    <= '0;
      end else begin
        rd_ptr_q <= rd_ptr_d;
        wr_ptr_q <= wr_ptr_d;
        cnt_q    <= cnt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr_q] <= din;
    end

    always_comb begin
      or_all = '0;
      for (int i = 0; i < DEPTH; i++) begin
        int off;
        off = (i >= int'(rd_ptr_q)) ? (i - int'(rd_ptr_q))
                                    : (i + DEPTH - int'(rd_ptr_q));
        if (off < int'(cnt_q)) or_all = or_all | mem[i][ORW-1:0];
      end
    end

    assign head  = mem[rd_ptr_q];
    assign count = cnt_q;

    AST_FIFO_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |-> (int'(cnt_q) < DEPTH)); // R6
    AST_FIFO_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0)); // R7
  end

endmodule

// File: rtl/aer_hlog_queue.sv
module aer_hlog_queue
  import aer_hlog_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       err_valid,
  input  logic [STAT_W-1:0]                          err_status,
  input  logic                                       err_hdr_valid,
  input  logic                                       err_pfx_present,
  input  logic [LOG_W-1:0]                           err_hdr,
  input  logic [LOG_W-1:0]                           err_pfx,
  input  logic                                       pfx_supported,
  input  logic                                       cfg_we,
  input  logic                                       cfg_sel,
  input  logic [STAT_W-1:0]                          cfg_wdata,
  output logic [STAT_W-1:0]                          unc_status,
  output logic [IDX_W-1:0]                           first_err_ptr,
  output logic                                       pfx_logged,
  output logic [LOG_W-1:0]                           hdr_log,
  output logic [LOG_W-1:0]                           pfx_log,
  output logic                                       mhr_capable,
  output logic                                       mhr_enable,
  output logic                                       err_reject,
  output logic                                       hdr_log_overflow,
  output logic [((DEPTH > 0) ? $clog2(DEPTH+1) : 1)-1:0] q_count
);

  localparam int   CW      = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1;
  localparam logic MHR_CAP = (DEPTH > 0);

  // live log and control state
  logic [STAT_W-1:0] status_q, status_d;
  logic [IDX_W-1:0]  fep_q, fep_d;
  logic              pfxv_q, pfxv_d;
  logic [LOG_W-1:0]  hdr_q, hdr_d;
  logic [LOG_W-1:0]  pfx_q, pfx_d;
  logic              mhr_q, mhr_d;
  logic              rej_q, ovf_q;
  logic              log_we;

  // queue interface
  err_rec_t          new_rec, head_rec;
  logic [REC_W-1:0]  head_raw;
  logic [CW-1:0]     q_cnt;
  logic [STAT_W-1:0] q_or;
  logic              q_push, q_pop, q_flush;

  // formatted candidates
  logic              new_ok, head_ok;
  logic [IDX_W-1:0]  new_idx, head_idx;
  logic [LOG_W-1:0]  new_hdr, new_pfx, head_hdr, head_pfx;
  logic              new_pfxv, head_pfxv;

  // intermediate state after the configuration write (R12)
  logic [STAT_W-1:0] st_a;
  logic              mhr_a;
  logic              use_head, clr_log;
  logic [IDX_W-1:0]  fep_a;
  logic [CW-1:0]     cnt_a;
  logic              take_new, rej_d, ovf_d;

  assign new_rec.status      = err_status;
  assign new_rec.hdr         = err_hdr;
  assign new_rec.pfx         = err_pfx;
  assign new_rec.hdr_valid   = err_hdr_valid;
  assign new_rec.pfx_present = err_pfx_present;
  assign head_rec            = err_rec_t'(head_raw);

  aer_hlog_fmt u_fmt_new (
    .rec           (new_rec),
    .pfx_supported (pfx_supported),
    .ok            (new_ok),
    .idx           (new_idx),
    .hdr_log       (new_hdr),
    .pfx_log       (new_pfx),
    .pfx_valid     (new_pfxv)
  );

  aer_hlog_fmt u_fmt_head (
    .rec           (head_rec),
    .pfx_supported (pfx_supported),
    .ok            (head_ok),
    .idx           (head_idx),
    .hdr_log       (head_hdr),
    .pfx_log       (head_pfx),
    .pfx_valid     (head_pfxv)
  );

  aer_hlog_fifo #(
    .DEPTH (DEPTH),
    .W     (REC_W),
    .ORW   (STAT_W)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (q_push),
    .din    (REC_W'(new_rec)),
    .pop    (q_pop),
    .flush  (q_flush),
    .head   (head_raw),
    .count  (q_cnt),
    .or_all (q_or)
  );

  // stage A: software write
  always_comb begin
    st_a     = status_q;
    mhr_a    = mhr_q;
    q_pop    = 1'b0;
    q_flush  = 1'b0;
    use_head = 1'b0;
    clr_log  = 1'b0;
    if (cfg_we) begin
      if (cfg_sel) mhr_a = cfg_wdata[0] & MHR_CAP;
      else         st_a  = status_q & ~cfg_wdata;
      if (!st_a[fep_q]) begin
        if (mhr_a && (q_cnt != '0)) begin
          st_a     = st_a | q_or;
          q_pop    = 1'b1;
          use_head = 1'b1;
        end else begin
          clr_log  = 1'b1;
        end
      end else if (mhr_a) begin
        st_a = st_a | q_or;
      end else begin
        q_flush = 1'b1;
      end
    end
    if (use_head)     fep_a = head_idx;
    else if (clr_log) fep_a = '0;
    else              fep_a = fep_q;
    if (q_flush)    cnt_a = '0;
    else if (q_pop) cnt_a = q_cnt - 1'b1;
    else            cnt_a = q_cnt;
  end

  // stage B: arriving error, judged on stage A results
  always_comb begin
    status_d = st_a;
    take_new = 1'b0;
    q_push   = 1'b0;
    rej_d    = 1'b0;
    ovf_d    = 1'b0;
    if (err_valid) begin
      if (!new_ok) begin
        rej_d = 1'b1;
      end else begin
        if (mhr_a && st_a[fep_a]) begin
          if (int'(cnt_a) == DEPTH) ovf_d  = 1'b1;
          else                      q_push = 1'b1;
        end else begin
          take_new = 1'b1;
        end
        status_d = st_a | err_status;
      end
    end
  end

  // next values of the live log
  always_comb begin
    log_we = take_new | use_head | clr_log;
    mhr_d  = mhr_a;
    if (take_new) begin
      fep_d  = new_idx;
      hdr_d  = new_hdr;
      pfx_d  = new_pfx;
      pfxv_d = new_pfxv;
    end else if (use_head) begin
      fep_d  = head_idx;
      hdr_d  = head_hdr;
      pfx_d  = head_pfx;
      pfxv_d = head_pfxv;
    end else if (clr_log) begin
      fep_d  = '0;
      hdr_d  = '0;
      pfx_d  = '0;
      pfxv_d = 1'b0;
    end else begin
      fep_d  = fep_q;
      hdr_d  = hdr_q;
      pfx_d  = pfx_q;
      pfxv_d = pfxv_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mhr_q    <= 1'b0;
      rej_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mhr_q    <= mhr_d;
      rej_q    <= rej_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fep_q  <= '0;
      hdr_q  <= '0;
      pfx_q  <= '0;
      pfxv_q <= 1'b0;
    end else if (log_we) begin
      fep_q  <= fep_d;
      hdr_q  <= hdr_d;
      pfx_q  <= pfx_d;
      pfxv_q <= pfxv_d;
    end
  end

  assign unc_status       = status_q;
  assign first_err_ptr    = fep_q;
  assign pfx_logged       = pfxv_q;
  assign hdr_log          = hdr_q;
  assign pfx_log          = pfx_q;
  assign mhr_capable      = MHR_CAP;
  assign mhr_enable       = mhr_q;
  assign err_reject       = rej_q;
  assign hdr_log_overflow = ovf_q;
  assign q_count          = q_cnt;

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !new_ok && !cfg_we) |=>
      (unc_status == $past(unc_status) && q_count == $past(q_count) &&
       first_err_ptr == $past(first_err_ptr))); // R1
  AST_LOGGED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    take_new |=> unc_status[first_err_ptr]); // R2
  AST_HDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take_new && !err_hdr_valid) |=> (hdr_log == '0)); // R3
  AST_PFX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_logged |-> (pfx_log == '0)); // R4
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_d |-> (int'(q_count) == DEPTH)); // R6
  AST_HEAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> head_ok); // R7
  AST_QUEUE_NEEDS_MHR: assert property (@(posedge clk) disable iff (!rst_n)
    !mhr_enable |-> (q_count == '0)); // R10
  AST_MHR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mhr_enable |-> mhr_capable); // R11

endmodule

// File: tb/aer_hlog_queue_bench.sv
`timescale 1ns/1ps
module aer_hlog_queue_bench;

  localparam int DEPTH = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         err_valid, err_hdr_valid, err_pfx_present, pfx_supported;
  logic [31:0]  err_status;
  logic [127:0] err_hdr, err_pfx;
  logic         cfg_we, cfg_sel;
  logic [31:0]  cfg_wdata;
  logic [31:0]  unc_status;
  logic [4:0]   first_err_ptr;
  logic         pfx_logged, mhr_capable, mhr_enable, err_reject, hdr_log_overflow;
  logic [127:0] hdr_log, pfx_log;
  logic [2:0]   q_count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit live  = 0;

  always #10 clk = ~clk;

  aer_hlog_queue #(.DEPTH(DEPTH)) u_aer_hlog_queue (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_status(err_status),
    .err_hdr_valid(err_hdr_valid), .err_pfx_present(err_pfx_present),
    .err_hdr(err_hdr), .err_pfx(err_pfx), .pfx_supported(pfx_supported),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .unc_status(unc_status), .first_err_ptr(first_err_ptr), .pfx_logged(pfx_logged),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .mhr_capable(mhr_capable),
    .mhr_enable(mhr_enable), .err_reject(err_reject),
    .hdr_log_overflow(hdr_log_overflow), .q_count(q_count)
  );

  // ---------------- reference model ----------------
  logic [31:0]  m_st;
  int           m_fep;
  bit           m_pfxv, m_mhr, m_rej, m_ovf;
  logic [127:0] m_hdr, m_pfx;
  logic [31:0]  q_st[$];
  logic [127:0] q_hdr[$], q_pfx[$];
  bit           q_hv[$], q_pp[$];

  function automatic logic [127:0] rev_bytes(input logic [127:0] x);
    logic [127:0] r;
    for (int d = 0; d < 4; d++) begin
      logic [31:0] w;
      w = x[d*32 +: 32];
      r[d*32 +: 32] = {w[7:0], w[15:8], w[23:16], w[31:24]};
    end
    return r;
  endfunction

  task automatic m_load(input logic [31:0] st, input bit hv, input bit pp,
                        input logic [127:0] h, input logic [127:0] p);
    for (int i = 0; i < 32; i++) if (st[i]) m_fep = i;
    m_hdr  = hv ? rev_bytes(h) : '0;
    m_pfxv = pp && pfx_supported;
    m_pfx  = m_pfxv ? rev_bytes(p) : '0;
  endtask

  task automatic m_step();
    logic [31:0] st;
    bit mhr;
    st = m_st; mhr = m_mhr; m_rej = 0; m_ovf = 0;
    if (cfg_we) begin
      if (cfg_sel) mhr = cfg_wdata[0];
      else st = st & ~cfg_wdata;
      if (!st[m_fep]) begin
        if (mhr && q_st.size() > 0) begin
          foreach (q_st[i]) st |= q_st[i];
          m_load(q_st[0], q_hv[0], q_pp[0], q_hdr[0], q_pfx[0]);
          void'(q_st.pop_front()); void'(q_hv.pop_front()); void'(q_pp.pop_front());
          void'(q_hdr.pop_front()); void'(q_pfx.pop_front());
        end else begin
          m_fep = 0; m_hdr = '0; m_pfx = '0; m_pfxv = 0;
        end
      end else if (mhr) begin
        foreach (q_st[i]) st |= q_st[i];
      end else begin
        q_st.delete(); q_hv.delete(); q_pp.delete(); q_hdr.delete(); q_pfx.delete();
      end
    end
    m_mhr = mhr;
    if (err_valid) begin
      if ($countones(err_status) != 1) m_rej = 1;
      else begin
        if (mhr && st[m_fep]) begin
          if (q_st.size() == DEPTH) m_ovf = 1;
          else begin
            q_st.push_back(err_status); q_hv.push_back(err_hdr_valid);
            q_pp.push_back(err_pfx_present); q_hdr.push_back(err_hdr);
            q_pfx.push_back(err_pfx);
          end
        end else m_load(err_status, err_hdr_valid, err_pfx_present, err_hdr, err_pfx);
        st |= err_status;
      end
    end
    m_st = st;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_fep = 0; m_pfxv = 0; m_mhr = 0; m_rej = 0; m_ovf = 0;
      m_hdr = '0; m_pfx = '0;
      q_st.delete(); q_hv.delete(); q_pp.delete(); q_hdr.delete(); q_pfx.delete();
    end else m_step();
  end

  // ---------------- checking ----------------
  task automatic chk(input string name, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R2/R7/R9 model unc_status", unc_status, m_st);
      chk("R2/R7/R8 model first_err_ptr", first_err_ptr, m_fep);
      chk("R3 model hdr_log", hdr_log, m_hdr);
      chk("R4 model pfx_log", pfx_log, m_pfx);
      chk("R4 model pfx_logged", pfx_logged, m_pfxv);
      chk("R11 model mhr_enable", mhr_enable, m_mhr);
      chk("R1 model err_reject", err_reject, m_rej);
      chk("R6 model hdr_log_overflow", hdr_log_overflow, m_ovf);
      chk("R5/R10 model q_count", q_count, q_st.size());
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    err_valid = 0; err_status = '0; err_hdr_valid = 0; err_pfx_present = 0;
    err_hdr = '0; err_pfx = '0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
  endtask

  task automatic set_err(input logic [31:0] st, input bit hv, input bit pp);
    err_valid = 1; err_status = st; err_hdr_valid = hv; err_pfx_present = pp;
    err_hdr = {32'hA0A1A2A3 ^ st, 32'h99887766, 32'h55667788, 32'h11223344};
    err_pfx = {32'hCAFEF00D, 32'h0BADBEEF, 32'h13572468, 32'hDEADBEEF};
  endtask

  task automatic send(input logic [31:0] st, input bit hv, input bit pp);
    set_err(st, hv, pp);
    @(negedge clk); idle();
  endtask

  task automatic cfg(input bit sel, input logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); idle();
  endtask

  initial begin
    rst_n = 0; pfx_supported = 1; idle();
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 status", unc_status, 0);
    chk("R13 q_count", q_count, 0);
    chk("R13 mhr_enable", mhr_enable, 0);
    chk("R11 capable", mhr_capable, 1);
    // R1 rejects
    send(32'h0, 1, 0);
    chk("R1 zero reject", err_reject, 1);
    send(32'h3, 1, 0);
    chk("R1 multi reject", err_reject, 1);
    chk("R1 status untouched", unc_status, 0);
    // R2 R3 R4 direct log
    send(32'h10, 1, 1);
    chk("R2 pointer", first_err_ptr, 4);
    chk("R2 status bit", unc_status, 32'h10);
    chk("R3 dword0 swapped", hdr_log[31:0], 32'h44332211);
    chk("R4 prefix logged", pfx_logged, 1);
    chk("R4 prefix dword0", pfx_log[31:0], 32'hEFBEADDE);
    // R5 recording off: overwrite; R3/R4 zeroing
    pfx_supported = 0;
    send(32'h20, 0, 1);
    chk("R5 overwrite pointer", first_err_ptr, 5);
    chk("R3 header zero", hdr_log, 0);
    chk("R4 unsupported prefix", pfx_logged, 0);
    pfx_supported = 1;
    // R8 clear with recording off
    cfg(0, 32'hFFFF_FFFF);
    chk("R8 pointer cleared", first_err_ptr, 0);
    chk("R8 status cleared", unc_status, 0);
    // R11 enable
    cfg(1, 32'h1);
    chk("R11 enable", mhr_enable, 1);
    // R5 queueing and R6 overflow
    send(32'h8, 1, 0);
    chk("R5 first logged", first_err_ptr, 3);
    send(32'h80, 1, 0);
    send(32'h200, 1, 0);
    send(32'h800, 1, 0);
    send(32'h1000, 1, 0);
    chk("R5 queued count", q_count, 4);
    chk("R5 pointer kept", first_err_ptr, 3);
    send(32'h2000, 1, 0);
    chk("R6 overflow pulse", hdr_log_overflow, 1);
    chk("R6 count stays", q_count, 4);
    chk("R2 dropped bit set", unc_status[13], 1);
    // R9 re-arm
    cfg(0, 32'h2080);
    chk("R9 queued bit re-armed", unc_status[7], 1);
    chk("R9 other bit cleared", unc_status[13], 0);
    // R7 advance
    cfg(0, 32'h8);
    chk("R7 next pointer", first_err_ptr, 7);
    chk("R7 count", q_count, 3);
    chk("R7 status", unc_status, 32'h1A80);
    cfg(0, 32'h80);
    chk("R7 oldest first", first_err_ptr, 9);
    // R12 write then error in same cycle
    set_err(32'h100000, 1, 0);
    cfg(0, 32'h200);
    chk("R12 pointer after pop", first_err_ptr, 11);
    chk("R12 error queued", q_count, 2);
    // R10 disable flushes
    cfg(1, 32'h0);
    chk("R10 flushed", q_count, 0);
    chk("R10 disabled", mhr_enable, 0);
    cfg(0, 32'hFFFF_FFFF);
    chk("R8 log cleared", hdr_log, 0);
    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      pfx_supported = $urandom_range(0, 3) != 0;
      if (r < 45) set_err((r < 5) ? 32'h0 : (r < 9) ? 32'h6 : (32'h1 << $urandom_range(0, 7)),
                          $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1;
        cfg_sel = $urandom_range(0, 4) == 0;
        cfg_wdata = cfg_sel ? 32'($urandom_range(0, 5) != 0)
                            : (32'h1 << $urandom_range(0, 7)) | (32'h1 << $urandom_range(0, 7));
      end
      @(negedge clk); idle();
    end
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule